// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block turns a fast output clock into two slow timing marks: a frame pulse that repeats once every `div_ratio + 1` clock cycles (8 kHz when `div_ratio` is set to the clock rate over 8 kHz, minus one), and a multiframe pulse that repeats once every four frames (2 kHz). Both marks come from one free-running counter and leave the block through flops clocked by that same clock, so each edge of either pulse falls on a clock edge. The multiframe pulse always starts in the same cycle as a frame pulse.

Each output has its own polarity control. Each also has its own width, counted in clock cycles and clamped so that the pulse can never fill its whole period. An optional external sync input at 8, 4 or 2 kHz can pull the counters into phase with another timing source. A rising edge on that input restarts the frame count. It also moves the multiframe position in a way that suits the stated rate of the input. A flag reports when the first frame pulse after such a realignment has been issued. The external sync input is assumed to be synchronous to `clk`.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst` is high, `fs_out` and `mfs_out` sit at their inactive level (the level of their invert input) and `align_done` is 0. The first frame pulse and the first multiframe pulse both start at the first clock edge after `rst` goes low.
- R2: The frame pulse repeats every `div_ratio + 1` cycles and is active for `fs_width` cycles.
- R3: The multiframe pulse repeats every `4 * (div_ratio + 1)` cycles and is active for `mfs_width` cycles. Each multiframe pulse starts in the same cycle as a frame pulse.
- R4: With `fs_invert` = 1 (or `mfs_invert` = 1) the output is low while active and high while idle. Without inversion, active is high.
- R5: A width of 0 keeps that output idle. A width that is at least the pulse period is clamped to period minus one cycles, so the output is idle for exactly one cycle per period.
- R6: With `ext_en` = 1, a rising edge of `ext_sync` seen at clock edge E reloads the frame count to zero at E. A new frame pulse then starts at edge E+1.
- R7: On a realignment the multiframe position follows `ext_rate`. Code 2'b00 (8 kHz) advances the multiframe position by one frame. Code 2'b01 (4 kHz) jumps to frame 2 from frames 0 or 1, and to frame 0 from frames 2 or 3. Codes 2'b10 and 2'b11 (2 kHz) jump to frame 0, so the multiframe pulse starts at E+1.
- R8: `align_done` goes to 0 at edge E of a realignment. It goes to 1 at edge E+1, together with the first frame pulse that follows.
- R9: With `ext_en` = 0, edges on `ext_sync` leave the pulse phase and `align_done` untouched.
- R10: Only a rising edge realigns. Holding `ext_sync` high afterwards does not restart the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock that the pulses are aligned to |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio | input | CNT_W | Frame period in cycles, minus one |
| fs_width | input | CNT_W | Frame pulse width in cycles |
| mfs_width | input | CNT_W+2 | Multiframe pulse width in cycles |
| fs_invert | input | 1 | 1 makes the frame pulse active low |
| mfs_invert | input | 1 | 1 makes the multiframe pulse active low |
| ext_en | input | 1 | Enables realignment from `ext_sync` |
| ext_rate | input | 2 | Rate of `ext_sync`: 00 = 8 kHz, 01 = 4 kHz, 1x = 2 kHz |
| ext_sync | input | 1 | External frame sync, synchronous to `clk` |
| fs_out | output | 1 | Frame sync pulse (8 kHz) |
| mfs_out | output | 1 | Multiframe sync pulse (2 kHz) |
| align_done | output | 1 | First frame pulse after a realignment has been issued |

## Verification
The bench builds the block with `CNT_W` = 8 and a divide setting of 9, and briefly 4. These give frames of 10 or 5 cycles and multiframes of 40 or 20 cycles, so a single run covers many periods, the clamping of widths larger than the period, and every realignment rate. With periods this short, every expected edge position, including the 2- and 3-frame gaps that follow a 4 kHz or 8 kHz realignment, can be counted cycle by cycle at the ports.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef enum logic [1:0] {
    EXT_8K  = 2'b00,
    EXT_4K  = 2'b01,
    EXT_2K  = 2'b10,
    EXT_2KB = 2'b11
  } ext_rate_e;
endpackage

// File: rtl/fsg_ext_edge.sv
module fsg_ext_edge (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic sync_i,
  output logic reload_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_i;
  end

  // restart only on a fresh rising edge while realignment is enabled
  assign reload_o = en_i & sync_i & ~prev_q;

  p_single_shot_r10: assert property (@(posedge clk) disable iff (rst)
    reload_o |=> !reload_o);
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_i,
  input  logic             reload_i,
  input  logic [1:0]       rate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W+1:0] mf_pos_o
);
  import fsg_pkg::*;
  localparam int MFW = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       idx_q;
  logic [MFW-1:0]   base_q;
  logic [MFW-1:0]   period;
  logic [MFW-1:0]   base_adv;
  logic             wrap;
  ext_rate_e        rate;

  assign rate     = ext_rate_e'(rate_i);
  assign period   = MFW'(div_i) + MFW'(1);
  assign wrap     = (cnt_q >= div_i);
  assign base_adv = (idx_q == 2'd3) ? '0 : base_q + period;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (reload_i) begin
      cnt_q <= '0;
      case (rate)
        EXT_8K: begin
          idx_q  <= idx_q + 2'd1;
          base_q <= base_adv;
        end
        EXT_4K: begin
          idx_q  <= {~idx_q[1], 1'b0};
          base_q <= idx_q[1] ? '0 : (period << 1);
        end
        default: begin
          idx_q  <= '0;
          base_q <= '0;
        end
      endcase
    end else if (wrap) begin
      cnt_q  <= '0;
      idx_q  <= idx_q + 2'd1;
      base_q <= base_adv;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o    = cnt_q;
  assign mf_pos_o = base_q + MFW'(cnt_q);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!reload_i && cnt_q < div_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_reload_zero_r6: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> (cnt_q == '0));
  p_frame_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(idx_q) |-> (cnt_q == '0));
  p_mf_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (mf_pos_o == '0) |-> (cnt_q == '0));
endmodule

// File: rtl/fsg_pulse_shaper.sv
module fsg_pulse_shaper #(
  parameter int PW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos_i,
  input  logic [PW-1:0] last_i,
  input  logic [PW-1:0] width_i,
  input  logic          invert_i,
  output logic          act_next_o,
  output logic          act_o,
  output logic          pulse_o
);
  logic [PW-1:0] w_eff;
  logic          act_q;
  logic          pulse_q;

  assign w_eff      = (width_i > last_i) ? last_i : width_i;
  assign act_next_o = (pos_i < w_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      pulse_q <= invert_i;
    end else begin
      act_q   <= act_next_o;
      pulse_q <= act_next_o ^ invert_i;
    end
  end

  assign act_o   = act_q;
  assign pulse_o = pulse_q;

  p_last_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (pos_i == last_i) |=> !act_q);
  p_zero_width_r5: assert property (@(posedge clk) disable iff (rst)
    (width_i == '0) |=> !act_q);
  p_polarity_r4: assert property (@(posedge clk) disable iff (rst)
    $stable(invert_i) |-> (pulse_q == (act_q ^ invert_i)));
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_ratio,
  input  logic [CNT_W-1:0] fs_width,
  input  logic [CNT_W+1:0] mfs_width,
  input  logic             fs_invert,
  input  logic             mfs_invert,
  input  logic             ext_en,
  input  logic [1:0]       ext_rate,
  input  logic             ext_sync,
  output logic             fs_out,
  output logic             mfs_out,
  output logic             align_done
);
  localparam int MFW  = CNT_W + 2;
  localparam int NOUT = 2;

  logic             reload;
  logic [CNT_W-1:0] cnt;
  logic [MFW-1:0]   mf_pos;
  logic [MFW-1:0]   pos_a   [NOUT];
  logic [MFW-1:0]   last_a  [NOUT];
  logic [MFW-1:0]   width_a [NOUT];
  logic             inv_a   [NOUT];
  logic             act_nxt [NOUT];
  logic             act_q   [NOUT];
  logic             pulse_a [NOUT];
  logic             pend_q;
  logic             done_q;

  fsg_ext_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .en_i     (ext_en),
    .sync_i   (ext_sync),
    .reload_o (reload)
  );

  fsg_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .div_i    (div_ratio),
    .reload_i (reload),
    .rate_i   (ext_rate),
    .cnt_o    (cnt),
    .mf_pos_o (mf_pos)
  );

  // channel 0: frame pulse, channel 1: multiframe pulse
  assign pos_a[0]   = MFW'(cnt);
  assign last_a[0]  = MFW'(div_ratio);
  assign width_a[0] = MFW'(fs_width);
  assign inv_a[0]   = fs_invert;
  assign pos_a[1]   = mf_pos;
  assign last_a[1]  = {div_ratio, 2'b11};
  assign width_a[1] = mfs_width;
  assign inv_a[1]   = mfs_invert;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    fsg_pulse_shaper #(.PW(MFW)) u_shape (
      .clk        (clk),
      .rst        (rst),
      .pos_i      (pos_a[g]),
      .last_i     (last_a[g]),
      .width_i    (width_a[g]),
      .invert_i   (inv_a[g]),
      .act_next_o (act_nxt[g]),
      .act_o      (act_q[g]),
      .pulse_o    (pulse_a[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (reload) begin
      pend_q <= 1'b1;
      done_q <= 1'b0;
    end else if (pend_q && act_nxt[0]) begin
      pend_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign fs_out     = pulse_a[0];
  assign mfs_out    = pulse_a[1];
  assign align_done = done_q;

  p_ext_off_r9: assert property (@(posedge clk) disable iff (rst)
    !ext_en |-> !reload);
  p_done_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> act_q[0]);
  p_done_cleared_r8: assert property (@(posedge clk) disable iff (rst)
    reload |=> !done_q);
  p_mf_on_frame_r3: assert property (@(posedge clk) disable iff (rst)
    (act_nxt[1] && !act_q[1] && $stable(mfs_width) && $stable(div_ratio))
      |-> (cnt == '0));
endmodule

// File: tb/sim_frame_sync_gen.sv
module sim_frame_sync_gen;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] div_ratio = 8'd9;
  logic [CNT_W-1:0] fs_width = 8'd3;
  logic [CNT_W+1:0] mfs_width = 10'd5;
  logic             fs_invert = 1'b0;
  logic             mfs_invert = 1'b0;
  logic             ext_en = 1'b0;
  logic [1:0]       ext_rate = 2'b00;
  logic             ext_sync = 1'b0;
  logic             fs_out, mfs_out, align_done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  frame_sync_gen #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .div_ratio(div_ratio), .fs_width(fs_width),
    .mfs_width(mfs_width), .fs_invert(fs_invert), .mfs_invert(mfs_invert),
    .ext_en(ext_en), .ext_rate(ext_rate), .ext_sync(ext_sync),
    .fs_out(fs_out), .mfs_out(mfs_out), .align_done(align_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit act(input int sel);
    if (sel == 0) return fs_out ^ fs_invert;
    return mfs_out ^ mfs_invert;
  endfunction

  task automatic wait_rise(input int sel);
    bit p;
    p = act(sel);
    forever begin
      @(negedge clk);
      if (act(sel) && !p) break;
      p = act(sel);
    end
  endtask

  // skip one full period, then measure active length and period
  task automatic measure(input int sel, output int hi, output int per);
    bit p, in_hi;
    int n;
    wait_rise(sel);
    wait_rise(sel);
    hi = 1; n = 0; in_hi = 1'b1; p = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      if (act(sel) && !p) break;
      if (in_hi && act(sel)) hi++;
      else in_hi = 1'b0;
      p = act(sel);
    end
    per = n;
  endtask

  // negedges from now until the next rise of the selected output
  task automatic gap_to_rise(input int sel, output int n);
    bit p;
    p = act(sel);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (act(sel) && !p) break;
      p = act(sel);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(fs_out == 1'b0, "R1 fs idle in reset", fs_out, 0);
    chk(mfs_out == 1'b0, "R1 mfs idle in reset", mfs_out, 0);
    chk(align_done == 1'b0, "R1 align_done in reset", align_done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(fs_out == 1'b1, "R1 first frame pulse", fs_out, 1);
    chk(mfs_out == 1'b1, "R1 first multiframe pulse", mfs_out, 1);
  endtask

  task automatic t_basic;
    int hi, per;
    measure(0, hi, per);
    chk(hi == 3, "R2 fs width", hi, 3);
    chk(per == 10, "R2 fs period", per, 10);
    measure(1, hi, per);
    chk(hi == 5, "R3 mfs width", hi, 5);
    chk(per == 40, "R3 mfs period", per, 40);
    wait_rise(1);
    chk(act(0) == 1'b1, "R3 mfs starts with fs", act(0), 1);
    div_ratio = 8'd4; fs_width = 8'd2; mfs_width = 10'd7;
    measure(0, hi, per);
    chk(hi == 2, "R2 fs width short frame", hi, 2);
    chk(per == 5, "R2 fs period short frame", per, 5);
    measure(1, hi, per);
    chk(hi == 7, "R3 mfs width spanning frames", hi, 7);
    chk(per == 20, "R3 mfs period short frame", per, 20);
    div_ratio = 8'd9; fs_width = 8'd3; mfs_width = 10'd5;
    repeat (50) @(negedge clk);
  endtask

  task automatic t_invert;
    int hi, per;
    fs_invert = 1'b1; mfs_invert = 1'b1;
    measure(0, hi, per);
    chk(hi == 3 && per == 10, "R4 inverted fs shape", hi * 100 + per, 310);
    measure(1, hi, per);
    chk(hi == 5 && per == 40, "R4 inverted mfs shape", hi * 100 + per, 540);
    wait_rise(0);
    chk(fs_out == 1'b0, "R4 inverted fs active low", fs_out, 0);
    repeat (5) @(negedge clk);
    chk(fs_out == 1'b1, "R4 inverted fs idle high", fs_out, 1);
    fs_invert = 1'b0; mfs_invert = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_clamp;
    int hi, per, cnt_act;
    fs_width = 8'd50; mfs_width = 10'd200;
    measure(0, hi, per);
    chk(hi == 9 && per == 10, "R5 fs clamp", hi * 100 + per, 910);
    measure(1, hi, per);
    chk(hi == 39 && per == 40, "R5 mfs clamp", hi * 100 + per, 3940);
    fs_width = 8'd0;
    repeat (2) @(negedge clk);
    cnt_act = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (act(0)) cnt_act++;
    end
    chk(cnt_act == 0, "R5 zero width stays idle", cnt_act, 0);
    fs_width = 8'd3; mfs_width = 10'd5;
    repeat (45) @(negedge clk);
  endtask

  // realign from inside multiframe frame 0; frames = expected gap to mfs
  task automatic t_realign(input logic [1:0] rate, input int frames, input string tag);
    int n;
    ext_en = 1'b1; ext_rate = rate;
    wait_rise(1);
    repeat (6) @(negedge clk);
    ext_sync = 1'b1;
    @(negedge clk);
    chk(align_done == 1'b0, {tag, " R8 done cleared"}, align_done, 0);
    @(negedge clk);
    chk(act(0) == 1'b1, {tag, " R6 fs restarts"}, act(0), 1);
    chk(align_done == 1'b1, {tag, " R8 done set"}, align_done, 1);
    ext_sync = 1'b0;
    if (frames == 0) begin
      chk(act(1) == 1'b1, {tag, " R7 mfs restarts"}, act(1), 1);
    end else begin
      chk(act(1) == 1'b0, {tag, " R7 mfs not yet"}, act(1), 0);
      gap_to_rise(1, n);
      chk(n == frames * 10, {tag, " R7 mfs gap"}, n, frames * 10);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_hold;
    int n;
    ext_en = 1'b1; ext_rate = 2'b10;
    wait_rise(0);
    repeat (4) @(negedge clk);
    ext_sync = 1'b1;
    repeat (2) @(negedge clk);
    chk(act(0) == 1'b1, "R10 first edge realigns", act(0), 1);
    gap_to_rise(0, n);
    chk(n == 10, "R10 held level no repeat", n, 10);
    ext_sync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ignore;
    int n;
    ext_en = 1'b0;
    wait_rise(0);
    repeat (4) @(negedge clk);
    ext_sync = 1'b1;
    repeat (2) @(negedge clk);
    ext_sync = 1'b0;
    gap_to_rise(0, n);
    chk(n + 6 == 10, "R9 disabled edge ignored", n + 6, 10);
    chk(align_done == 1'b1, "R9 done untouched", align_done, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_invert();
    t_clamp();
    t_realign(2'b10, 0, "2k");
    t_realign(2'b01, 2, "4k");
    t_realign(2'b00, 3, "8k");
    t_realign(2'b11, 0, "2k-alt");
    t_hold();
    t_ignore();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule